// File: doc/BRIEF.md
# Trinary Pulse-Pair Receiver

This block recovers trinary digits from a serial line on which each digit is sent as two positive pulses, each either short or long. The line is first passed through a two-flop synchronizer. Each rising edge starts a width measurement in units of a sample tick. At a fixed decision point the block checks whether the line is still high and calls the pulse long or short. Consecutive pulses are then paired into a digit: short-short is zero, long-long is one and long-short is open. The pair short-long is illegal and raises an error strobe instead of a digit.

A silence timer counts ticks while the line stays low and restarts on every edge. A moderate silence marks the gap between two words and produces a word-end strobe. That strobe carries a bad-word flag when the word had the wrong number of digits, an illegal pair, or a leftover unpaired pulse. It also clears the pairing phase and the digit count. A longer silence marks the end of the transmission. The timer then goes idle and stays idle until the next rising edge.

The digit output is a valid-only stream with no back-pressure. A serial line cannot be paused, so the consumer must take every `digit_valid` cycle as it comes. All strobes last a single clock cycle. All thresholds are parameters counted in ticks, and the counters advance only on cycles where `tick` is high.

Top module: `trinary_rx`

## Requirements
- R1: While reset is asserted and after its release, all output strobes are low until line activity produces an event. An idle low line after reset produces no word-end and no transmission-end.
- R2: A pulse is classified as long when the synchronized line stays high for more than LONG_AT_TICKS ticks after its rising edge, and as short when it stays high for LONG_AT_TICKS ticks or fewer.
- R3: Two short pulses give a digit with code 2'b00 (zero). Two long pulses give code 2'b01 (one). Long then short gives code 2'b10 (open). Each pair raises `digit_valid` for exactly one cycle, and code 2'b11 never appears.
- R4: A short pulse followed by a long pulse raises `pair_err` for one cycle and does not raise `digit_valid`.
- R5: `word_end` pulses once when a low run exceeds GAP_TICKS ticks after activity. A low run of exactly GAP_TICKS ticks produces none.
- R6: `xmit_end` pulses once when a low run exceeds END_TICKS ticks. A run of exactly END_TICKS produces none. After `xmit_end`, no further word-end or transmission-end occurs until a new rising edge.
- R7: A word end clears the pulse-pair phase and the digit count, so a leftover pulse never pairs with the first pulse of the next word.
- R8: `word_bad` is high only together with `word_end`. It is high exactly when the ending word held a digit count other than WORD_DIGITS, an illegal pair, or an unpaired pulse.
- R9: The width and silence counters advance only on cycles with `tick` high. While `tick` is low, no word-end or transmission-end is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Asynchronous serial line |
| tick | input | 1 | Sample tick; counters advance only when high |
| digit_valid | output | 1 | One-cycle strobe: a digit was decoded |
| digit_code | output | 2 | Digit code: 00 zero, 01 one, 10 open |
| pair_err | output | 1 | One-cycle strobe: illegal short-long pair |
| word_end | output | 1 | One-cycle strobe: between-word silence seen |
| word_bad | output | 1 | Qualifies `word_end`: the ending word is invalid |
| xmit_end | output | 1 | One-cycle strobe: end-of-transmission silence seen |

## Verification
The two functions that can meet in one cycle are the silence timer reaching its gap threshold and a new rising edge restarting that timer. The bench provokes this by placing a low run of exactly GAP_TICKS ticks between two digits, and then repeating the pattern with a run one tick longer. In the first case the edge must win: no word end appears and the word decodes whole. In the second case a word end must split the word, and both halves must be flagged bad. The same boundary is exercised at END_TICKS for the transmission-end strobe.

// File: rtl/trx_pkg.sv
package trx_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_OPEN = 2'b10
  } sym_code_e;

endpackage

// File: rtl/trx_sync.sv
module trx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              level_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = level & ~level_d;
  assign fall  = ~level & level_d;
endmodule

// File: rtl/trx_width_class.sv
module trx_width_class #(
  parameter int LONG_AT_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  input  logic rise,
  output logic pulse_valid,
  output logic pulse_long
);
  localparam int CW = $clog2(LONG_AT_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(LONG_AT_TICKS - 1);

  logic          armed;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed       <= 1'b0;
      cnt         <= '0;
      pulse_valid <= 1'b0;
      pulse_long  <= 1'b0;
    end else begin
      pulse_valid <= 1'b0;
      if (rise) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && tick) begin
        if (cnt == LAST) begin
          armed       <= 1'b0;
          pulse_valid <= 1'b1;
          pulse_long  <= level;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trx_silence.sv
module trx_silence #(
  parameter int GAP_TICKS = 20,
  parameter int END_TICKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic level,
  input  logic rise,
  input  logic fall,
  output logic gap_seen,
  output logic end_seen
);
  localparam int SW = $clog2(END_TICKS + 1);
  localparam logic [SW-1:0] GAP_LAST = SW'(GAP_TICKS - 1);
  localparam logic [SW-1:0] END_LAST = SW'(END_TICKS - 1);
  localparam logic [SW-1:0] END_SAT  = SW'(END_TICKS);

  logic          active;
  logic [SW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      low_cnt  <= '0;
      gap_seen <= 1'b0;
      end_seen <= 1'b0;
    end else begin
      gap_seen <= 1'b0;
      end_seen <= 1'b0;
      if (rise || fall) begin
        low_cnt <= '0;
        if (rise) active <= 1'b1;
      end else if (tick && !level && active && low_cnt != END_SAT) begin
        low_cnt  <= low_cnt + 1'b1;
        gap_seen <= (low_cnt == GAP_LAST);
        end_seen <= (low_cnt == END_LAST);
        if (low_cnt == END_LAST) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trx_pairer.sv
module trx_pairer
  import trx_pkg::*;
#(
  parameter int WORD_DIGITS = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pulse_valid,
  input  logic       pulse_long,
  input  logic       gap_seen,
  output logic       digit_valid,
  output logic [1:0] digit_code,
  output logic       pair_err,
  output logic       word_bad
);
  localparam int DW = $clog2(WORD_DIGITS + 2);
  localparam logic [DW-1:0] EXPECT = DW'(WORD_DIGITS);
  localparam logic [DW-1:0] SAT    = DW'(WORD_DIGITS + 1);

  logic          phase;
  logic          first_long;
  logic          err_seen;
  logic [DW-1:0] dcnt;
  sym_code_e     code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= 1'b0;
      first_long  <= 1'b0;
      err_seen    <= 1'b0;
      dcnt        <= '0;
      digit_valid <= 1'b0;
      pair_err    <= 1'b0;
      code_q      <= SYM_ZERO;
    end else begin
      digit_valid <= 1'b0;
      pair_err    <= 1'b0;
      if (gap_seen) begin
        phase    <= 1'b0;
        err_seen <= 1'b0;
        dcnt     <= '0;
      end else if (pulse_valid) begin
        if (!phase) begin
          phase      <= 1'b1;
          first_long <= pulse_long;
        end else begin
          phase <= 1'b0;
          if (!first_long && pulse_long) begin
            pair_err <= 1'b1;
            err_seen <= 1'b1;
          end else begin
            digit_valid <= 1'b1;
            if (dcnt != SAT) dcnt <= dcnt + 1'b1;
            case ({first_long, pulse_long})
              2'b00:   code_q <= SYM_ZERO;
              2'b11:   code_q <= SYM_ONE;
              default: code_q <= SYM_OPEN;
            endcase
          end
        end
      end
    end
  end

  assign digit_code = code_q;
  assign word_bad   = gap_seen & ((dcnt != EXPECT) | err_seen | phase);
endmodule

// File: rtl/trinary_rx.sv
module trinary_rx #(
  parameter int SYNC_STAGES   = 2,
  parameter int LONG_AT_TICKS = 4,
  parameter int GAP_TICKS     = 20,
  parameter int END_TICKS     = 40,
  parameter int WORD_DIGITS   = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_in,
  input  logic       tick,
  output logic       digit_valid,
  output logic [1:0] digit_code,
  output logic       pair_err,
  output logic       word_end,
  output logic       word_bad,
  output logic       xmit_end
);
  logic level, rise, fall;
  logic pulse_valid, pulse_long;

  trx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(line_in),
    .level(level), .rise(rise), .fall(fall)
  );

  trx_width_class #(.LONG_AT_TICKS(LONG_AT_TICKS)) class_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level), .rise(rise),
    .pulse_valid(pulse_valid), .pulse_long(pulse_long)
  );

  trx_silence #(.GAP_TICKS(GAP_TICKS), .END_TICKS(END_TICKS)) quiet_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level), .rise(rise),
    .fall(fall), .gap_seen(word_end), .end_seen(xmit_end)
  );

  trx_pairer #(.WORD_DIGITS(WORD_DIGITS)) pair_i (
    .clk(clk), .rst_n(rst_n), .pulse_valid(pulse_valid),
    .pulse_long(pulse_long), .gap_seen(word_end),
    .digit_valid(digit_valid), .digit_code(digit_code),
    .pair_err(pair_err), .word_bad(word_bad)
  );
endmodule

// File: rtl/trinary_rx_chk.sv
module trinary_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       digit_valid,
  input logic [1:0] digit_code,
  input logic       pair_err,
  input logic       word_end,
  input logic       word_bad,
  input logic       xmit_end
);
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    digit_valid |-> digit_code != 2'b11);

  a_r4_err_no_digit: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |-> !digit_valid);

  a_r5_gap_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> !word_end);

  a_r6_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_end |=> (!xmit_end && !word_end));

  a_r7_no_digit_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |=> !digit_valid);

  a_r8_bad_with_end: assert property (@(posedge clk) disable iff (!rst_n)
    word_bad |-> word_end);

  a_r9_tick_gates_events: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> (!word_end && !xmit_end));
endmodule

bind trinary_rx trinary_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .digit_valid(digit_valid),
  .digit_code(digit_code), .pair_err(pair_err), .word_end(word_end),
  .word_bad(word_bad), .xmit_end(xmit_end)
);

// File: tb/trinary_rx_tb_top.sv
`timescale 1ns/1ps
module trinary_rx_tb_top;
  localparam int LONG_AT = 4;
  localparam int GAP     = 20;
  localparam int ENDT    = 40;
  localparam int WORDN   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_in = 1'b0;
  logic tick = 1'b1;
  logic digit_valid, pair_err, word_end, word_bad, xmit_end;
  logic [1:0] digit_code;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int n_dig = 0, n_err = 0, n_eow = 0, n_eot = 0, n_bad = 0;
  logic [1:0] codes [512];

  always #10 clk = ~clk;

  trinary_rx #(.LONG_AT_TICKS(LONG_AT), .GAP_TICKS(GAP), .END_TICKS(ENDT),
               .WORD_DIGITS(WORDN)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .tick(tick),
    .digit_valid(digit_valid), .digit_code(digit_code), .pair_err(pair_err),
    .word_end(word_end), .word_bad(word_bad), .xmit_end(xmit_end)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (digit_valid) begin
        codes[n_dig % 512] = digit_code;
        n_dig++;
      end
      if (pair_err) n_err++;
      if (word_end) n_eow++;
      if (word_end && word_bad) n_bad++;
      if (xmit_end) n_eot++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    line_in = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int hi, input int lo);
    line_in = 1'b1;
    repeat (hi) @(negedge clk);
    line_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  // digit t: 0 = short,short  1 = long,long  2 = long,short
  task automatic send_digit(input int t);
    case (t)
      0: begin pulse(2, 6); pulse(2, 6); end
      1: begin pulse(6, 2); pulse(6, 2); end
      default: begin pulse(6, 2); pulse(2, 6); end
    endcase
  endtask

  function automatic int seq(input int base, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) r |= int'(codes[(base + i) % 512]) << (2 * i);
    return r;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int b_dig, b_err, b_eow, b_eot, b_bad;
    repeat (4) @(negedge clk);
    check({digit_valid, pair_err, word_end, word_bad, xmit_end} == 5'b0, "R1",
          "strobes in reset", {digit_valid, pair_err, word_end, xmit_end}, 0);
    rst_n = 1'b1;
    idle(100);
    check(n_eow == 0 && n_eot == 0, "R1", "idle after reset events",
          n_eow + n_eot, 0);

    // R3 R5 R8: exhaustive sweep of all 3-digit words
    for (int w = 0; w < 27; w++) begin
      int t0, t1, t2, exp;
      t0 = w % 3; t1 = (w / 3) % 3; t2 = w / 9;
      b_dig = n_dig; b_eow = n_eow; b_bad = n_bad;
      send_digit(t0); send_digit(t1); send_digit(t2);
      idle(30);
      exp = t0 | (t1 << 2) | (t2 << 4);
      check(n_dig - b_dig == 3 && seq(b_dig, 3) == exp, "R3",
            "word codes", seq(b_dig, 3), exp);
      check(n_eow - b_eow == 1 && n_bad == b_bad, "R5",
            "one good word end", (n_eow - b_eow) * 10 + (n_bad - b_bad), 10);
    end
    b_eot = n_eot;
    idle(60);
    check(n_eot - b_eot == 1, "R6", "end of transmission", n_eot - b_eot, 1);

    // R2 R8: width threshold sweep, single-digit words are bad
    for (int w = 1; w <= 8; w++) begin
      int exp;
      b_dig = n_dig; b_bad = n_bad;
      pulse(w, 10); pulse(w, 10);
      idle(30);
      exp = (w > LONG_AT) ? 1 : 0;
      check(n_dig - b_dig == 1 && int'(codes[b_dig % 512]) == exp, "R2",
            "width class", int'(codes[b_dig % 512]), exp);
      check(n_bad - b_bad == 1, "R8", "short word flagged", n_bad - b_bad, 1);
    end
    idle(60);

    // R4: short-long pair
    b_dig = n_dig; b_err = n_err; b_bad = n_bad;
    pulse(2, 6); pulse(6, 2);
    send_digit(0); send_digit(2);
    idle(30);
    check(n_err - b_err == 1, "R4", "pair error strobe", n_err - b_err, 1);
    check(n_dig - b_dig == 2, "R4", "no digit for bad pair", n_dig - b_dig, 2);
    check(n_bad - b_bad == 1, "R8", "word with bad pair", n_bad - b_bad, 1);

    // R7: leftover pulse must not pair across a word end
    b_bad = n_bad;
    send_digit(0); send_digit(1); send_digit(2);
    pulse(2, 6);
    idle(30);
    check(n_bad - b_bad == 1, "R8", "leftover pulse flagged", n_bad - b_bad, 1);
    b_dig = n_dig; b_err = n_err; b_bad = n_bad;
    send_digit(1); send_digit(1); send_digit(1);
    idle(30);
    check(n_dig - b_dig == 3 && seq(b_dig, 3) == 6'b010101 && n_err == b_err,
          "R7", "next word after leftover", seq(b_dig, 3), 6'b010101);
    check(n_bad == b_bad, "R7", "next word good", n_bad - b_bad, 0);
    idle(60);

    // R5: low run of exactly GAP ticks meets a new edge: no word end
    b_dig = n_dig; b_eow = n_eow; b_bad = n_bad;
    pulse(6, 2); pulse(6, GAP);
    send_digit(1); send_digit(1);
    idle(30);
    check(n_eow - b_eow == 1 && n_bad == b_bad, "R5", "gap of exactly threshold",
          n_eow - b_eow, 1);
    check(n_dig - b_dig == 3, "R5", "word kept whole", n_dig - b_dig, 3);
    // one tick longer splits the word
    b_eow = n_eow; b_bad = n_bad;
    pulse(6, 2); pulse(6, GAP + 1);
    send_digit(1); send_digit(1);
    idle(30);
    check(n_eow - b_eow == 2, "R5", "gap one over threshold", n_eow - b_eow, 2);
    check(n_bad - b_bad == 2, "R8", "both halves bad", n_bad - b_bad, 2);

    // R6: low run of exactly END ticks gives no transmission end
    b_eot = n_eot; b_eow = n_eow;
    send_digit(0); send_digit(0);
    pulse(2, 6); pulse(2, ENDT);
    check(n_eot == b_eot && n_eow - b_eow == 1, "R6", "run of exactly end ticks",
          n_eot - b_eot, 0);
    send_digit(0); send_digit(0); send_digit(0);
    idle(60);
    check(n_eot - b_eot == 1, "R6", "end after long run", n_eot - b_eot, 1);
    b_eot = n_eot; b_eow = n_eow;
    idle(200);
    check(n_eot == b_eot && n_eow == b_eow, "R6", "quiet after end",
          (n_eot - b_eot) + (n_eow - b_eow), 0);

    // R9: tick held low freezes the silence timer
    b_eow = n_eow; b_eot = n_eot;
    send_digit(2); send_digit(2); send_digit(2);
    idle(5);
    tick = 1'b0;
    idle(100);
    check(n_eow == b_eow && n_eot == b_eot, "R9", "no events without tick",
          n_eow - b_eow, 0);
    tick = 1'b1;
    idle(25);
    check(n_eow - b_eow == 1 && n_eot == b_eot, "R9", "timer resumes on tick",
          n_eow - b_eow, 1);
    idle(60);
    check(n_eot - b_eot == 1, "R9", "end after resume", n_eot - b_eot, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule